// File: doc/BRIEF.md
# Phase-Accumulator PWM Generator with Staged Configuration

This block generates one pulse-width-modulated output from a phase accumulator that advances by a programmable step on every clock. The output frequency is `step * f_clk / 2^INC_W`. The duty cycle comes from an inverted 8-bit threshold that is compared against the top eight bits of the accumulator.

Software controls the block through a single 32-bit configuration word. Step and threshold values are first written into a shadow copy. Software then raises a commit request bit. The shadow values move into the active settings at the next accumulator wrap, which is the start of a new output period. At that moment the hardware drops the request bit. Software polls that bit through the readback port before staging another change. While a request is outstanding, field writes are discarded, so the running waveform cannot be corrupted and the block cannot lock up.

Top module: `pwm_accum_gen`

## Requirements
- R1: Word layout: bit 31 is the run enable, bit 30 is the commit request, bits 8 and up (INC_W bits) hold the step and bits 7:0 hold the threshold. Readback returns the enable, the request flag and the shadow step and threshold, with every other bit zero.
- R2: While enabled, the INC_W-bit accumulator adds the active step on every clock, wrapping modulo 2^INC_W. The period is therefore 2^INC_W/step clocks.
- R3: The output is high exactly when the top eight accumulator bits exceed the active threshold. The high fraction is therefore (255 - threshold)/256: threshold 255 gives a constant low, and threshold 0 gives 255/256.
- R4: A write of step or threshold with the request bit clear changes only the shadow copy. The waveform keeps using the active settings.
- R5: A pending request is committed on the clock where the running accumulator wraps. The shadow values become active and the request flag clears.
- R6: While a request is pending, written step and threshold values and further requests are ignored. Readback keeps the values that were staged.
- R7: With enable low, the accumulator is held at zero and the output is low. After enable rises, the accumulator counts up from zero.
- R8: An active step of zero freezes the accumulator, so the output stays constant.
- R9: When no period is running (enable low or active step zero), a pending request commits on the next clock.
- R10: Reset clears every field and the accumulator, and drives the output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word to write |
| cfg_rdata | output | 32 | Configuration readback |
| pwm_out | output | 1 | PWM output |

## Verification
A table of step/threshold pairs drives the waveform. The high clocks are counted over a 256-clock window, which spans a whole number of periods for every power-of-two step in the table.

- Steps 1, 16, 32, 64 and 128 separate the period arithmetic from the threshold compare. Thresholds 0, 255 and exact multiples of the step expose off-by-one errors between a greater-than and a greater-or-equal compare.
- Consecutive table rows are committed while the accumulator is running, so a commit at the wrong moment shows up as a wrong count.
- Directed cases stage values without a request, write during a pending request, stop and restart the enable, and freeze on a zero step. Each of these has its own visible count or cycle pattern.

// File: rtl/pwm_cfg_pkg.sv
package pwm_cfg_pkg;
    localparam int CFG_W    = 32;
    localparam int EN_BIT   = 31;
    localparam int REQ_BIT  = 30;
    localparam int THR_W    = 8;
    localparam int STEP_LSB = 8;
endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
    import pwm_cfg_pkg::*;
#(
    parameter int INC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             wrap,
    output logic             run,
    output logic             pend,
    output logic [INC_W-1:0] act_step,
    output logic [THR_W-1:0] act_thr,
    output logic [CFG_W-1:0] rd_data
);
    localparam int STEP_MSB = STEP_LSB + INC_W - 1;

    typedef struct packed {
        logic             en;
        logic             req;
        logic [INC_W-1:0] sh_step;
        logic [THR_W-1:0] sh_thr;
        logic [INC_W-1:0] ac_step;
        logic [THR_W-1:0] ac_thr;
    } regs_t;

    regs_t r_q, r_d;
    logic  idle;
    logic  commit;

    always_comb begin
        r_d    = r_q;
        idle   = !r_q.en || (r_q.ac_step == '0);
        commit = r_q.req && (idle || wrap);
        if (wr_en) begin
            r_d.en = wr_data[EN_BIT];
            if (!r_q.req) begin
                r_d.sh_step = wr_data[STEP_MSB:STEP_LSB];
                r_d.sh_thr  = wr_data[THR_W-1:0];
                r_d.req     = wr_data[REQ_BIT];
            end
        end
        if (commit) begin
            r_d.ac_step = r_q.sh_step;
            r_d.ac_thr  = r_q.sh_thr;
            r_d.req     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rd_data                     = '0;
        rd_data[EN_BIT]             = r_q.en;
        rd_data[REQ_BIT]            = r_q.req;
        rd_data[STEP_MSB:STEP_LSB]  = r_q.sh_step;
        rd_data[THR_W-1:0]          = r_q.sh_thr;
    end

    assign run      = r_q.en;
    assign pend     = r_q.req;
    assign act_step = r_q.ac_step;
    assign act_thr  = r_q.ac_thr;

    // R6: shadow untouched by writes while a request is outstanding
    assert_holdoff_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.req && wr_en) |=> ($stable(r_q.sh_step) && $stable(r_q.sh_thr)));

    // R4: active settings move only when a request was pending
    assert_active_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.req |=> ($stable(r_q.ac_step) && $stable(r_q.ac_thr)));

    // R5: clearing the request coincides with the shadow becoming active
    assert_commit_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.req) |-> (r_q.ac_step == $past(r_q.sh_step) && r_q.ac_thr == $past(r_q.sh_thr)));
endmodule

// File: rtl/pwm_phase_acc.sv
module pwm_phase_acc #(
    parameter int INC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [INC_W-1:0] step,
    output logic [INC_W-1:0] acc,
    output logic             wrap
);
    logic [INC_W-1:0] acc_q, acc_d;
    logic [INC_W:0]   sum;

    always_comb begin
        sum   = {1'b0, acc_q} + {1'b0, step};
        wrap  = run && sum[INC_W];
        acc_d = run ? sum[INC_W-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign acc = acc_q;

    // R7: stopped accumulator returns to zero
    assert_off_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (acc_q == '0));

    // R8: zero step freezes the phase
    assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && step == '0) |=> $stable(acc_q));
endmodule

// File: rtl/pwm_accum_gen.sv
module pwm_accum_gen
    import pwm_cfg_pkg::*;
#(
    parameter int INC_W = 8  // 8..22 so the step field fits below bit 30
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        pwm_out
);
    logic             run;
    logic             pend;
    logic             wrap;
    logic [INC_W-1:0] act_step;
    logic [THR_W-1:0] act_thr;
    logic [INC_W-1:0] acc;
    logic [THR_W-1:0] phase_top;

    pwm_cfg_regs #(.INC_W(INC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_data(cfg_wdata),
        .wrap(wrap), .run(run), .pend(pend), .act_step(act_step),
        .act_thr(act_thr), .rd_data(cfg_rdata)
    );

    pwm_phase_acc #(.INC_W(INC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .run(run), .step(act_step),
        .acc(acc), .wrap(wrap)
    );

    assign phase_top = acc[INC_W-1 -: THR_W];
    assign pwm_out   = run && (phase_top > act_thr);

    // R5: a wrap with a pending request always clears it
    assert_wrap_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && pend) |=> !pend);
endmodule

// File: tb/tb_pwm_accum_gen.sv
module tb_pwm_accum_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        pwm_out;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pwm_accum_gen dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .pwm_out(pwm_out)
    );

    localparam int NV = 8;
    localparam int V_STEP [NV] = '{1, 1, 1, 64, 64, 16, 128, 32};
    localparam int V_THR  [NV] = '{0, 255, 100, 127, 0, 200, 127, 31};
    localparam int V_HIGH [NV] = '{255, 0, 155, 128, 192, 48, 128, 224};

    function automatic logic [31:0] word(bit en, bit req, int step, int thr);
        return {en, req, 14'b0, step[7:0], thr[7:0]};
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [31:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_clear(string req);
        int n = 0;
        while (cfg_rdata[30] && n < 2000) begin
            @(negedge clk); n++;
        end
        check(!cfg_rdata[30], req, cfg_rdata[30], 0);
    endtask

    task automatic count_high(output int c);
        c = 0;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            if (pwm_out) c++;
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int c;
        repeat (3) @(negedge clk);
        check(cfg_rdata == 32'h0, "R10 rdata", cfg_rdata, 0);
        check(pwm_out == 1'b0, "R10 out", pwm_out, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk; each commit after the first lands on a running wrap (R2 R3 R5)
        for (int v = 0; v < NV; v++) begin
            wr(word(1, 1, V_STEP[v], V_THR[v]));
            check(cfg_rdata == word(1, 1, V_STEP[v], V_THR[v]), "R1 readback", cfg_rdata,
                  word(1, 1, V_STEP[v], V_THR[v]));
            wait_clear("R5 request clears");
            count_high(c);
            check(c == V_HIGH[v], "R2/R3 high count", c, V_HIGH[v]);
        end

        // R5: with step 1 the period is 256, so the request is still pending shortly after
        wr(word(1, 1, 1, 200));
        wait_clear("R5 setup");
        wr(word(1, 1, 64, 0));
        repeat (3) @(negedge clk);
        // pending unless a wrap happened in this short span
        wait_clear("R5 eventual commit");
        count_high(c);
        check(c == 192, "R5 new settings", c, 192);

        // R6: a write during a pending request is dropped
        wr(word(1, 1, 1, 200));
        wr(word(1, 1, 16, 0));
        check(cfg_rdata[15:0] == {8'd1, 8'd200}, "R6 shadow kept", cfg_rdata[15:0], {8'd1, 8'd200});
        wait_clear("R6 commit");
        count_high(c);
        check(c == 55, "R6 active uncorrupted", c, 55);

        // R4: staging without a request leaves the waveform alone
        wr(word(1, 0, 64, 0));
        check(cfg_rdata == word(1, 0, 64, 0), "R4 shadow visible", cfg_rdata, word(1, 0, 64, 0));
        count_high(c);
        check(c == 55, "R4 no effect", c, 55);
        repeat (300) @(negedge clk);
        check(cfg_rdata[30] == 1'b0, "R4 no request", cfg_rdata[30], 0);
        wr(word(1, 1, 64, 0));
        wait_clear("R4 commit");
        count_high(c);
        check(c == 192, "R4 after commit", c, 192);

        // R7: stop then restart from zero; step 64 threshold 127 gives L L H H L
        wr(word(1, 1, 64, 127));
        wait_clear("R7 setup");
        wr(word(0, 0, 64, 127));
        check(pwm_out == 1'b0, "R7 low when off", pwm_out, 0);
        count_high(c);
        check(c == 0, "R7 stays low", c, 0);
        wr(word(1, 0, 64, 127));
        check(pwm_out == 1'b0, "R7 phase 0", pwm_out, 0);
        @(negedge clk); check(pwm_out == 1'b0, "R7 phase 64", pwm_out, 0);
        @(negedge clk); check(pwm_out == 1'b1, "R7 phase 128", pwm_out, 1);
        @(negedge clk); check(pwm_out == 1'b1, "R7 phase 192", pwm_out, 1);
        @(negedge clk); check(pwm_out == 1'b0, "R7 wrap to 0", pwm_out, 0);

        // R8: zero step freezes at phase 0, output constant low
        wr(word(1, 1, 0, 0));
        wait_clear("R8 commit");
        count_high(c);
        check(c == 0, "R8 frozen", c, 0);

        // R9: frozen block commits on the next clock
        wr(word(1, 1, 64, 127));
        @(negedge clk);
        check(cfg_rdata[30] == 1'b0, "R9 idle commit (step 0)", cfg_rdata[30], 0);
        count_high(c);
        check(c == 128, "R9 runs after commit", c, 128);

        // R9: disabled block commits on the next clock
        wr(word(0, 1, 16, 200));
        @(negedge clk);
        check(cfg_rdata[30] == 1'b0, "R9 idle commit (off)", cfg_rdata[30], 0);
        wr(word(1, 0, 16, 200));
        count_high(c);
        check(c == 48, "R9 settings applied", c, 48);

        // R10: reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(cfg_rdata == 32'h0, "R10 rdata mid-run", cfg_rdata, 0);
        check(pwm_out == 1'b0, "R10 out mid-run", pwm_out, 0);
        rst_n = 1'b1;
        count_high(c);
        check(c == 0, "R10 idle after reset", c, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule